// File: doc/BRIEF.md
# Serial Controller Register File with Prioritised Interrupt

This block is the software-visible register set of a byte-oriented asynchronous serial controller. A host reaches eight byte registers through a 3-bit offset with separate read and write strobes. Behind those registers sit a transmit holding queue, a receive holding queue, the baud divisor, the line format, the modem control and modem status registers, a scratch byte, and a four-source interrupt encoder that drives one `irq` line.

The serializer, the deserializer and the baud generator are outside this block. The block offers queued transmit characters on a valid/ready stream (`tx_valid`/`tx_ready`/`tx_data`). A character leaves the queue on any cycle where both valid and ready are high, and `tx_data` holds steady while valid is high and ready is low. Received characters come in on `rx_valid` with their error flags. That stream has no back-pressure: a character that finds the receive queue full is dropped and recorded as an overrun. `ser_idle` tells the block that the transmit shift register is empty. Several reads have side effects. Reading the line status register clears its error flags. Reading the interrupt identification register withdraws a pending transmit-empty interrupt. Reading modem status clears its change bits.

The parameter `FIFO16` selects the queue depth: 16 entries when it is 1, a single holding register when it is 0. The offsets are: 0 data/divisor-low, 1 interrupt-enable/divisor-high, 2 interrupt identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line control reads 0x03, interrupt enable, modem control, modem status, scratch and the divisor read 0, the interrupt identification reads 0xC1, `irq` is low and `tx_valid` is low. With `ser_idle` high, line status reads 0x60.
- R2: While line-control bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes, shown on `divisor` as {high,low}. The data queues and the interrupt-enable register are untouched.
- R3: Writes to offset 0 (bit 7 clear) join the transmit queue (16 or 1 entries) and leave in order on the tx stream. A write into a full queue is discarded. Line status bit 5 is 1 exactly when the queue is empty, and bit 6 is 1 when the queue is empty and `ser_idle` is high.
- R4: Each `rx_valid` character is queued. Reading offset 0 returns the oldest character and removes it, and returns 0 when the queue is empty. Line status bit 0 is 1 while the queue holds data.
- R5: A character arriving while the receive queue is full is dropped and sets line status bit 1.
- R6: `rx_perr`, `rx_ferr` and `rx_brk` set line status bits 2, 3 and 4. A read of line status returns the value, then clears bits 4:1. A flag arriving in the same cycle as the read stays set.
- R7: The interrupt identification reads as 0xC0 OR'd with the code: 0x01 none, 0x06 line error, 0x04 receive data, 0x02 transmit empty, 0x00 modem change. A read of it clears the transmit-empty pending flag. That flag is set each time the serializer takes a character and is cleared by a write to offset 0.
- R8: Interrupt sources in priority order, with their enables in interrupt-enable bits 2, 0, 1 and 3: line error (any of status bits 4:1); receive data (bit 0); transmit empty (status bit 5 and the pending flag both set); modem change (any modem-status bit 3:0). Interrupt-enable bits 7:4 read 0.
- R9: Modem status bits 7:4 follow the lines {DCD,RI,DSR,CTS}. Normally these come from `modem_in[3:0]`. With modem-control bit 4 set, they come from modem-control bits {3,2,0,1}. A change on CTS, DSR or DCD sets bit 0, 1 or 3. A read of modem status clears bits 3:0.
- R10: Modem-status bit 2 is set only when RI falls from 1 to 0, never when it rises.
- R11: `irq` is high exactly when bit 0 of the interrupt identification is 0.
- R12: Line control and scratch store all 8 bits. Modem control stores bits 4:0, and bits 4:0 read back with 0 above them. `line_cfg` shows the line control register.
- R13: `modem_out` equals modem-control bits 3:0, and is forced to 0 while modem-control bit 4 (loopback) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tx_valid | output | 1 | Transmit queue holds a character |
| tx_ready | input | 1 | Serializer accepts the offered character |
| tx_data | output | 8 | Oldest transmit character |
| ser_idle | input | 1 | Transmit shift register is empty |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error with this character |
| rx_ferr | input | 1 | Framing error with this character |
| rx_brk | input | 1 | Break detected with this character |
| modem_in | input | 4 | External {DCD,RI,DSR,CTS} |
| modem_out | output | 4 | {OUT2,OUT1,RTS,DTR}, zero in loopback |
| divisor | output | 16 | Baud divisor to the rate generator |
| line_cfg | output | 8 | Line control register to the serial engines |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the transmit queue one entry past its depth. A design that wrapped the pointer would then send the seventeenth character in place of the first. It also overflows the receive queue and checks that the flag is set while the stored data keeps the first sixteen characters; a design that overwrote the head would lose the oldest byte. The bench reads line status and modem status twice in a row to show that the clear-on-read acts after the returned value and hits only the error and change bits. In loopback it raises and then drops the ring line, which catches an edge detector that fires on the rising edge. It steps through the interrupt sources by clearing them one at a time, so a wrong priority order or a transmit-empty interrupt that survives an identification read shows up as a wrong code.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IER   = 3'd1;
  localparam logic [2:0] OFS_IIR   = 3'd2;
  localparam logic [2:0] OFS_LCR   = 3'd3;
  localparam logic [2:0] OFS_MCR   = 3'd4;
  localparam logic [2:0] OFS_LSR   = 3'd5;
  localparam logic [2:0] OFS_MSR   = 3'd6;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  localparam int IE_RXD   = 0;
  localparam int IE_THR   = 1;
  localparam int IE_LINE  = 2;
  localparam int IE_MODEM = 3;

  localparam int LCR_DLAB = 7;
  localparam int MCR_LOOP = 4;

  localparam logic [7:0] LCR_RESET = 8'h03;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_THR   = 4'h2,
    ID_RXD   = 4'h4,
    ID_LINE  = 4'h6
  } irq_id_e;
endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_msr.sv
module uart_rf_msr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loop_en,
  input  logic [3:0] mcr_lines,  // {out2,out1,rts,dtr}
  input  logic [3:0] ext_lines,  // {dcd,ri,dsr,cts}
  input  logic       clr,
  output logic [7:0] msr
);
  logic [3:0] src, line_q, delta_q, delta_new;

  always_comb begin
    if (loop_en) src = {mcr_lines[3], mcr_lines[2], mcr_lines[0], mcr_lines[1]};
    else         src = ext_lines;
    delta_new[0] = line_q[0] ^ src[0];
    delta_new[1] = line_q[1] ^ src[1];
    delta_new[2] = line_q[2] & ~src[2];
    delta_new[3] = line_q[3] ^ src[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      delta_q <= '0;
    end else begin
      line_q  <= src;
      delta_q <= (clr ? 4'b0 : delta_q) | delta_new;
    end
  end

  assign msr = {line_q, delta_q};
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic [3:0] ier,
  input  logic       line_err,
  input  logic       rx_ready,
  input  logic       thr_empty,
  input  logic       thr_pend,
  input  logic       modem_chg,
  output irq_id_e    id
);
  always_comb begin
    if (ier[IE_LINE] && line_err)                    id = ID_LINE;
    else if (ier[IE_RXD] && rx_ready)                id = ID_RXD;
    else if (ier[IE_THR] && thr_empty && thr_pend)   id = ID_THR;
    else if (ier[IE_MODEM] && modem_chg)             id = ID_MODEM;
    else                                             id = ID_NONE;
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int FIFO16 = 1,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          ser_idle,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic [3:0]    modem_in,
  output logic [3:0]    modem_out,
  output logic [2*DW-1:0] divisor,
  output logic [DW-1:0] line_cfg,
  output logic          irq
);
  localparam int DEPTH = (FIFO16 != 0) ? 16 : 1;

  logic [DW-1:0] lcr, scr, dl_lo, dl_hi;
  logic [3:0]    ier;
  logic [4:0]    mcr;
  logic [3:0]    err_q;      // {brk, ferr, perr, overrun}
  logic          thr_pend;
  logic [7:0]    msr, lsr;
  irq_id_e       iir_id;

  logic dlab, loop_en;
  logic wr_data, rd_data, rd_lsr, rd_iir, rd_msr;
  logic tx_empty, tx_full, tx_pop;
  logic rx_empty, rx_full, rx_push;
  logic [DW-1:0] rx_dout;

  assign dlab    = lcr[LCR_DLAB];
  assign loop_en = mcr[MCR_LOOP];
  assign wr_data = bus_wr && bus_addr == OFS_DATA && !dlab;
  assign rd_data = bus_rd && bus_addr == OFS_DATA && !dlab;
  assign rd_lsr  = bus_rd && bus_addr == OFS_LSR;
  assign rd_iir  = bus_rd && bus_addr == OFS_IIR;
  assign rd_msr  = bus_rd && bus_addr == OFS_MSR;
  assign tx_pop  = tx_valid && tx_ready;
  assign rx_push = rx_valid && !rx_full;

  uart_rf_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_data), .din(bus_wdata),
    .pop(tx_ready), .dout(tx_data), .empty(tx_empty), .full(tx_full));

  uart_rf_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data),
    .pop(rd_data), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  uart_rf_msr u_msr (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .mcr_lines(mcr[3:0]),
    .ext_lines(modem_in), .clr(rd_msr), .msr(msr));

  uart_rf_irq u_irq (
    .ier(ier), .line_err(|err_q), .rx_ready(!rx_empty),
    .thr_empty(tx_empty), .thr_pend(thr_pend),
    .modem_chg(|msr[3:0]), .id(iir_id));

  assign tx_valid  = !tx_empty;
  assign lsr       = {1'b0, tx_empty && ser_idle, tx_empty, err_q, !rx_empty};
  assign irq       = (iir_id != ID_NONE);
  assign modem_out = loop_en ? 4'b0 : mcr[3:0];
  assign divisor   = {dl_hi, dl_lo};
  assign line_cfg  = lcr;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr   <= LCR_RESET;
      scr   <= '0;
      dl_lo <= '0;
      dl_hi <= '0;
      ier   <= '0;
      mcr   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DATA: if (dlab) dl_lo <= bus_wdata;
        OFS_IER:  if (dlab) dl_hi <= bus_wdata; else ier <= bus_wdata[3:0];
        OFS_LCR:  lcr <= bus_wdata;
        OFS_MCR:  mcr <= bus_wdata[4:0];
        OFS_SCR:  scr <= bus_wdata;
        default:  ;
      endcase
    end
  end

  // Line status error bits: arrival wins over clear-on-read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else begin
      err_q <= (rd_lsr ? 4'b0 : err_q)
             | {rx_valid && rx_brk, rx_valid && rx_ferr,
                rx_valid && rx_perr, rx_valid && rx_full};
    end
  end

  // Transmit-empty pending flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   thr_pend <= 1'b0;
    else if (wr_data || rd_iir)   thr_pend <= 1'b0;
    else if (tx_pop)              thr_pend <= 1'b1;
  end

  // Read data
  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = dlab ? dl_lo : (rx_empty ? '0 : rx_dout);
      OFS_IER:  bus_rdata = dlab ? dl_hi : {4'b0, ier};
      OFS_IIR:  bus_rdata = {4'b1100, iir_id};
      OFS_LCR:  bus_rdata = lcr;
      OFS_MCR:  bus_rdata = {3'b0, mcr};
      OFS_LSR:  bus_rdata = lsr;
      OFS_MSR:  bus_rdata = msr;
      default:  bus_rdata = scr;
    endcase
  end

  logic unused_ok;
  assign unused_ok = tx_full;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       rx_valid,
  input logic       rx_full,
  input logic [3:0] err_q,
  input logic       irq
);
  // R3: offered character holds under back-pressure
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R5: arrival on a full queue flags overrun
  a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_full |=> err_q[0]);

  // R6: status read with no arrival leaves no error bits
  a_r6_lsr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 3'd5 && !rx_valid |=> err_q == 4'b0);

  // R7: identification top bits read as ones
  a_r7_iir_top: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 3'd2 |-> bus_rdata[7:6] == 2'b11);

  // R11: interrupt line agrees with identification bit 0
  a_r11_irq_iir: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 3'd2 |-> irq == !bus_rdata[0]);
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_valid(rx_valid), .rx_full(rx_full),
  .err_q(err_q), .irq(irq));

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic ser_idle = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [3:0] modem_in = '0, modem_out;
  logic [15:0] divisor;
  logic [7:0] line_cfg;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_regfile u_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .ser_idle(ser_idle), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .modem_in(modem_in), .modem_out(modem_out), .divisor(divisor),
    .line_cfg(line_cfg), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bread(a, v);
    chk(req, {8'h0, v}, {8'h0, exp});
  endtask

  task automatic rx_put(input logic [7:0] d, input logic pe, input logic fe, input logic bi);
    @(negedge clk); rx_data = d; rx_perr = pe; rx_ferr = fe; rx_brk = bi; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic tx_take(input string req, input logic [7:0] exp);
    @(negedge clk); #1;
    chk(req, {8'h0, 7'h0, tx_valid}, 16'h1);
    chk(req, {8'h0, tx_data}, {8'h0, exp});
    tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 tx_valid", {15'h0, tx_valid}, 16'h0);
    chk("R1 divisor", divisor, 16'h0);
    chk("R1 line_cfg", {8'h0, line_cfg}, 16'h0003);
    rd_chk("R1 lcr", 3'd3, 8'h03);
    rd_chk("R1 ier", 3'd1, 8'h00);
    rd_chk("R1 mcr", 3'd4, 8'h00);
    rd_chk("R1 lsr", 3'd5, 8'h60);
    rd_chk("R1 iir", 3'd2, 8'hC1);
    rd_chk("R1 msr", 3'd6, 8'h00);
    rd_chk("R1 scr", 3'd7, 8'h00);
  endtask

  task automatic t_plain_regs;
    bwrite(3'd7, 8'hA5);
    rd_chk("R12 scratch", 3'd7, 8'hA5);
    bwrite(3'd1, 8'hF0);
    rd_chk("R8 ier upper bits read 0", 3'd1, 8'h00);
    bwrite(3'd4, 8'hEF);
    rd_chk("R12 mcr width", 3'd4, 8'h0F);
    #1 chk("R13 modem_out", {12'h0, modem_out}, 16'h000F);
    bwrite(3'd4, 8'h00);
    bwrite(3'd3, 8'h1B);
    #1 chk("R12 line_cfg", {8'h0, line_cfg}, 16'h001B);
    rd_chk("R12 lcr", 3'd3, 8'h1B);
    bwrite(3'd3, 8'h03);
  endtask

  task automatic t_divisor;
    bwrite(3'd3, 8'h83);
    bwrite(3'd0, 8'h34);
    bwrite(3'd1, 8'h12);
    #1 chk("R2 divisor port", divisor, 16'h1234);
    chk("R2 no tx char", {15'h0, tx_valid}, 16'h0);
    rd_chk("R2 dl low", 3'd0, 8'h34);
    rd_chk("R2 dl high", 3'd1, 8'h12);
    bwrite(3'd3, 8'h03);
    rd_chk("R2 ier untouched", 3'd1, 8'h00);
    rd_chk("R2 lsr untouched", 3'd5, 8'h60);
  endtask

  task automatic t_tx_queue;
    for (int i = 0; i < 17; i++) bwrite(3'd0, 8'(i * 3 + 1));
    rd_chk("R3 lsr not empty", 3'd5, 8'h00);
    for (int i = 0; i < 16; i++) tx_take("R3 order", 8'(i * 3 + 1));
    #1 chk("R3 17th dropped", {15'h0, tx_valid}, 16'h0);
    rd_chk("R3 lsr empty idle", 3'd5, 8'h60);
    ser_idle = 1'b0;
    rd_chk("R3 lsr shifter busy", 3'd5, 8'h20);
    ser_idle = 1'b1;
  endtask

  task automatic t_rx_queue;
    rx_put(8'h41, 0, 0, 0);
    rx_put(8'h42, 0, 0, 0);
    rd_chk("R4 lsr ready", 3'd5, 8'h61);
    rd_chk("R4 first", 3'd0, 8'h41);
    rd_chk("R4 second", 3'd0, 8'h42);
    rd_chk("R4 empty read", 3'd0, 8'h00);
    rd_chk("R4 lsr drained", 3'd5, 8'h60);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 17; i++) rx_put(8'(8'h80 + i), 0, 0, 0);
    rd_chk("R5 overrun set", 3'd5, 8'h63);
    rd_chk("R6 overrun cleared", 3'd5, 8'h61);
    for (int i = 0; i < 16; i++) rd_chk("R5 kept data", 3'd0, 8'(8'h80 + i));
    rd_chk("R5 dropped byte absent", 3'd0, 8'h00);
  endtask

  task automatic t_line_flags;
    rx_put(8'h55, 1, 1, 1);
    rd_chk("R6 flags set", 3'd5, 8'h7D);
    rd_chk("R6 flags cleared", 3'd5, 8'h61);
    // flag arriving together with the status read stays set
    @(negedge clk); bus_addr = 3'd5; bus_rd = 1'b1; rx_data = 8'h66; rx_ferr = 1'b1; rx_valid = 1'b1;
    @(negedge clk); bus_rd = 1'b0; rx_valid = 1'b0; rx_ferr = 1'b0;
    rd_chk("R6 set wins over clear", 3'd5, 8'h69);
    rd_chk("R6 data 1", 3'd0, 8'h55);
    rd_chk("R6 data 2", 3'd0, 8'h66);
  endtask

  task automatic t_loopback;
    bwrite(3'd4, 8'h12);
    #1 chk("R13 outputs off in loopback", {12'h0, modem_out}, 16'h0);
    @(negedge clk);
    rd_chk("R9 rts to cts with delta", 3'd6, 8'h11);
    rd_chk("R9 delta cleared on read", 3'd6, 8'h10);
    bwrite(3'd4, 8'h14);
    @(negedge clk);
    rd_chk("R10 ri rise no trailing edge", 3'd6, 8'h41);
    bwrite(3'd4, 8'h10);
    @(negedge clk);
    rd_chk("R10 ri fall trailing edge", 3'd6, 8'h04);
    bwrite(3'd4, 8'h00);
    modem_in = 4'b1000;
    @(negedge clk); @(negedge clk);
    rd_chk("R9 external dcd", 3'd6, 8'h88);
    modem_in = 4'b0000;
    @(negedge clk); @(negedge clk);
    rd_chk("R9 external dcd drop", 3'd6, 8'h08);
    rd_chk("R9 quiet", 3'd6, 8'h00);
  endtask

  task automatic t_priority;
    logic [7:0] v;
    rx_put(8'h77, 1, 0, 0);
    bwrite(3'd1, 8'h0F);
    #1 chk("R11 irq high", {15'h0, irq}, 16'h1);
    rd_chk("R8 line first", 3'd2, 8'hC6);
    rd_chk("R6 lsr parity", 3'd5, 8'h65);
    rd_chk("R8 rx data next", 3'd2, 8'hC4);
    bread(3'd0, v);
    chk("R4 data", {8'h0, v}, 16'h0077);
    rd_chk("R7 pend cleared by iir read", 3'd2, 8'hC1);
    #1 chk("R11 irq low", {15'h0, irq}, 16'h0);
    bwrite(3'd0, 8'h99);
    tx_take("R3 single", 8'h99);
    #1 chk("R11 irq thr", {15'h0, irq}, 16'h1);
    rd_chk("R8 thr empty", 3'd2, 8'hC2);
    rd_chk("R7 thr withdrawn", 3'd2, 8'hC1);
    bwrite(3'd4, 8'h11);
    @(negedge clk);
    rd_chk("R8 modem last", 3'd2, 8'hC0);
    rd_chk("R9 dtr to dsr", 3'd6, 8'h22);
    rd_chk("R8 none", 3'd2, 8'hC1);
    bwrite(3'd4, 8'h00);
    @(negedge clk);
    bread(3'd6, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain_regs();
    t_divisor();
    t_tx_queue();
    t_rx_queue();
    t_overrun();
    t_line_flags();
    t_loopback();
    t_priority();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule